// File: doc/BRIEF.md
# Serial EEPROM Port Arbiter

This block is a single host-visible control register that lets software drive an external one-bit serial EEPROM by toggling pins directly. The EEPROM sits behind a memory port that other clients also use. Before any pin can move, software must win that port. It sets a request bit, and the block waits for the port's busy indication to fall. The block then takes ownership and raises a ready flag.

While the block owns the port, three stored register bits drive the EEPROM chip select, serial clock and data-out pins. A read-only bit shows the EEPROM's data-out pin. The ready flag gives software a pacing timer. Any register write made while the block owns the port clears ready, and ready returns a fixed 800 ns later. That delay is a cycle count derived from the clock-period parameter. Clearing the request bit releases the port in the same write.

The register layout is fixed because software decodes it. Bit 7 is grant status (read-only) and bit 6 is request pending (read-only). Bit 5 is the port request (read/write) and bit 4 is ready (read-only). Bit 3 is chip select, bit 2 is serial clock and bit 1 is data out, all read/write. Bit 0 is data in (read-only).

Top module: `eeprom_bitbang_port`

## Requirements
- R1: After reset the read value is 0x00, `portReq` and `portOwned` are low, and all three EEPROM pins are low.
- R2: A write with bit 5 set raises `portReq` on the next cycle. While bit 5 is set and the port is not yet owned, read bit 6 (pending) is 1.
- R3: Ownership (`portOwned`, read bit 7) is taken only at a clock edge where the stored request is set and `portBusy` is low. While `portBusy` stays high, no grant occurs.
- R4: At the edge where ownership is taken, ready (read bit 4) rises together with `portOwned`, with no timed delay.
- R5: While the port is not owned, `eeCs`, `eeSck` and `eeDo` stay low. Values written to bits 3..1 are still stored and read back.
- R6: While the port is owned, `eeCs`, `eeSck` and `eeDo` equal the stored bits 3, 2 and 1.
- R7: Read bit 0 equals `eeDataIn` while the port is owned and reads 0 otherwise.
- R8: A write made while owned, with bit 5 set, clears ready at the write edge. Ready rises again exactly ceil(800000 / CLK_PS) cycles after that edge, which is 200 cycles at 4 ns.
- R9: A write made during that countdown restarts it, so ready rises the full delay after the latest write.
- R10: A write with bit 5 clear drops `portReq`, `portOwned` and ready, and forces all pins low at that write's edge.
- R11: Write data in bits 7, 6, 4 and 0 has no effect on the read value or on any output.
- R12: Once the port is owned, `portBusy` has no effect on ownership, ready or the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read value |
| portBusy | input | 1 | Shared memory port is serving another client |
| portReq | output | 1 | Request/hold of the shared memory port |
| portOwned | output | 1 | Port is granted and connected to the EEPROM |
| eeCs | output | 1 | EEPROM chip select |
| eeSck | output | 1 | EEPROM serial clock |
| eeDo | output | 1 | Data toward the EEPROM input |
| eeDataIn | input | 1 | Data from the EEPROM output |

## Verification
Several wrong internal states are visible at the ports within one cycle. A lost or spurious grant flag shows up the very next cycle as pins that leak before ownership, or as ready and bit 7 disagreeing with `portOwned`. A stuck request bit shows up as `portReq` staying high after a release write. A pacing counter that is off by one, or that fails to restart, stays hidden until the countdown ends. It then shows as ready rising one cycle early or late, or 800 ns after the first write of a burst instead of the last. For that reason the reference model is compared against every port on every clock through whole countdowns.

// File: rtl/eeprom_port_pkg.sv
`timescale 1ns/1ps
package eeprom_port_pkg;

  // Register bit positions (software decodes these)
  localparam int unsigned BitGrant   = 7;
  localparam int unsigned BitPending = 6;
  localparam int unsigned BitReq     = 5;
  localparam int unsigned BitReady   = 4;
  localparam int unsigned BitCs      = 3;
  localparam int unsigned BitSck     = 2;
  localparam int unsigned BitDo      = 1;
  localparam int unsigned BitDi      = 0;

  // Control view handed from the control FSM to the datapath
  typedef struct packed {
    logic owned;
    logic ready;
    logic pending;
  } ctrlView_t;

  function automatic int unsigned delayCycles(int unsigned clkPs, int unsigned delayPs);
    return (delayPs + clkPs - 1) / clkPs;
  endfunction

endpackage

// File: rtl/eeprom_port_ctrl.sv
`timescale 1ns/1ps
module eeprom_port_ctrl
  import eeprom_port_pkg::*;
#(
  parameter int unsigned CLK_PS   = 4000,
  parameter int unsigned DELAY_PS = 800000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrEn,
  input  logic      wrReqBit,
  input  logic      reqStored,
  input  logic      portBusy,
  output ctrlView_t view
);

  localparam int unsigned DlyCyc = delayCycles(CLK_PS, DELAY_PS);
  localparam int unsigned CntW   = (DlyCyc > 1) ? $clog2(DlyCyc) : 1;
  localparam logic [CntW-1:0] CntLast = CntW'(DlyCyc - 1);

  logic            owned;
  logic            ready;
  logic            timing;
  logic [CntW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      owned  <= 1'b0;
      ready  <= 1'b0;
      timing <= 1'b0;
      cnt    <= '0;
    end else if (wrEn && !wrReqBit) begin
      owned  <= 1'b0;
      ready  <= 1'b0;
      timing <= 1'b0;
      cnt    <= '0;
    end else if (owned) begin
      if (wrEn) begin
        ready  <= 1'b0;
        timing <= 1'b1;
        cnt    <= '0;
      end else if (timing) begin
        if (cnt == CntLast) begin
          ready  <= 1'b1;
          timing <= 1'b0;
          cnt    <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end else if (reqStored && !portBusy) begin
      owned  <= 1'b1;
      ready  <= 1'b1;
      timing <= 1'b0;
      cnt    <= '0;
    end
  end

  always_comb begin
    view.owned   = owned;
    view.ready   = ready;
    view.pending = reqStored && !owned;
  end

endmodule

// File: rtl/eeprom_port_dp.sv
`timescale 1ns/1ps
module eeprom_port_dp
  import eeprom_port_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  ctrlView_t  view,
  input  logic       eeDataIn,
  output logic       reqStored,
  output logic [7:0] rdData,
  output logic       eeCs,
  output logic       eeSck,
  output logic       eeDo
);

  logic csBit;
  logic sckBit;
  logic doBit;
  logic unusedWrBits;

  assign unusedWrBits = ^{wrData[BitGrant], wrData[BitPending], wrData[BitReady], wrData[BitDi]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqStored <= 1'b0;
      csBit     <= 1'b0;
      sckBit    <= 1'b0;
      doBit     <= 1'b0;
    end else if (wrEn) begin
      reqStored <= wrData[BitReq];
      csBit     <= wrData[BitCs];
      sckBit    <= wrData[BitSck];
      doBit     <= wrData[BitDo];
    end
  end

  always_comb begin
    eeCs  = view.owned && csBit;
    eeSck = view.owned && sckBit;
    eeDo  = view.owned && doBit;

    rdData             = '0;
    rdData[BitGrant]   = view.owned;
    rdData[BitPending] = view.pending;
    rdData[BitReq]     = reqStored;
    rdData[BitReady]   = view.ready;
    rdData[BitCs]      = csBit;
    rdData[BitSck]     = sckBit;
    rdData[BitDo]      = doBit;
    rdData[BitDi]      = view.owned && eeDataIn;
  end

endmodule

// File: rtl/eeprom_bitbang_port.sv
`timescale 1ns/1ps
module eeprom_bitbang_port
  import eeprom_port_pkg::*;
#(
  parameter int unsigned CLK_PS   = 4000,
  parameter int unsigned DELAY_PS = 800000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       portBusy,
  output logic       portReq,
  output logic       portOwned,
  output logic       eeCs,
  output logic       eeSck,
  output logic       eeDo,
  input  logic       eeDataIn
);

  ctrlView_t view;
  logic      reqStored;

  eeprom_port_ctrl #(.CLK_PS(CLK_PS), .DELAY_PS(DELAY_PS)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (regWrEn),
    .wrReqBit (regWrData[BitReq]),
    .reqStored(reqStored),
    .portBusy (portBusy),
    .view     (view)
  );

  eeprom_port_dp i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (regWrEn),
    .wrData   (regWrData),
    .view     (view),
    .eeDataIn (eeDataIn),
    .reqStored(reqStored),
    .rdData   (regRdData),
    .eeCs     (eeCs),
    .eeSck    (eeSck),
    .eeDo     (eeDo)
  );

  assign portReq   = reqStored;
  assign portOwned = view.owned;

endmodule

// File: rtl/eeprom_port_checker.sv
`timescale 1ns/1ps
module eeprom_port_checker
  import eeprom_port_pkg::*;
#(
  parameter int unsigned CLK_PS   = 4000,
  parameter int unsigned DELAY_PS = 800000
) (
  input logic       clk,
  input logic       rstN,
  input logic       regWrEn,
  input logic [7:0] regWrData,
  input logic [7:0] regRdData,
  input logic       portBusy,
  input logic       portReq,
  input logic       portOwned,
  input logic       eeCs,
  input logic       eeSck,
  input logic       eeDo
);

  localparam int unsigned DlyCyc = delayCycles(CLK_PS, DELAY_PS);

  // cycles since the last register write, saturating
  int unsigned sinceWr;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceWr <= DlyCyc + 2;
    else if (regWrEn)          sinceWr <= 0;
    else if (sinceWr < DlyCyc + 2) sinceWr <= sinceWr + 1;
  end

  a_r3_grant_needs_idle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(portOwned) |-> ($past(portReq) && !$past(portBusy)));

  a_r4_ready_at_grant: assert property (@(posedge clk) disable iff (!rstN)
    $rose(portOwned) |-> regRdData[BitReady]);

  a_r5_pins_idle: assert property (@(posedge clk) disable iff (!rstN)
    !portOwned |-> (!eeCs && !eeSck && !eeDo));

  a_r6_pins_follow: assert property (@(posedge clk) disable iff (!rstN)
    portOwned |-> (eeCs == regRdData[BitCs] && eeSck == regRdData[BitSck] && eeDo == regRdData[BitDo]));

  a_r8_write_clears_ready: assert property (@(posedge clk) disable iff (!rstN)
    (portOwned && regWrEn && regWrData[BitReq]) |=> !regRdData[BitReady]);

  a_r8_ready_delay: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(regRdData[BitReady]) && $past(portOwned)) |-> (sinceWr == DlyCyc));

  a_r10_release: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regWrData[BitReq]) |=> (!portOwned && !portReq && !regRdData[BitReady]));

  a_r12_ready_implies_owned: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[BitReady] |-> portOwned);

endmodule

bind eeprom_bitbang_port eeprom_port_checker #(.CLK_PS(CLK_PS), .DELAY_PS(DELAY_PS)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWrEn  (regWrEn),
  .regWrData(regWrData),
  .regRdData(regRdData),
  .portBusy (portBusy),
  .portReq  (portReq),
  .portOwned(portOwned),
  .eeCs     (eeCs),
  .eeSck    (eeSck),
  .eeDo     (eeDo)
);

// File: tb/test_eeprom_bitbang_port.sv
`timescale 1ns/1ps
module test_eeprom_bitbang_port;

  localparam int unsigned ClkPs = 4000;
  localparam int Dly = 200; // 800 ns / 4 ns

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       portBusy = 1'b0;
  logic       portReq;
  logic       portOwned;
  logic       eeCs, eeSck, eeDo;
  logic       eeDataIn = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  eeprom_bitbang_port #(.CLK_PS(ClkPs), .DELAY_PS(800000)) i_eeprom_bitbang_port (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .portBusy(portBusy), .portReq(portReq), .portOwned(portOwned),
    .eeCs(eeCs), .eeSck(eeSck), .eeDo(eeDo), .eeDataIn(eeDataIn)
  );

  // Behavioural reference model
  bit mReq, mCs, mSck, mDo, mOwned, mReady;
  int mLeft; // cycles until ready returns, -1 when idle

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mReq = 0; mCs = 0; mSck = 0; mDo = 0; mOwned = 0; mReady = 0; mLeft = -1;
    end else begin
      bit grantNow;
      grantNow = !mOwned && mReq && !portBusy;
      if (regWrEn && !regWrData[5]) begin
        mOwned = 0; mReady = 0; mLeft = -1;
      end else if (mOwned) begin
        if (regWrEn) begin
          mReady = 0; mLeft = Dly;
        end else if (mLeft > 0) begin
          mLeft--;
          if (mLeft == 0) begin mReady = 1; mLeft = -1; end
        end
      end else if (grantNow) begin
        mOwned = 1; mReady = 1; mLeft = -1;
      end
      if (regWrEn) begin
        mReq = regWrData[5]; mCs = regWrData[3]; mSck = regWrData[2]; mDo = regWrData[1];
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare every port against the model away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      logic [7:0] expRd;
      expRd = {mOwned, mReq && !mOwned, mReq, mReady, mCs, mSck, mDo, mOwned && eeDataIn};
      check(portReq == mReq, "R2 portReq", portReq, mReq);
      check(portOwned == mOwned, "R3 portOwned", portOwned, mOwned);
      check(regRdData[4] == mReady, "R8 ready", regRdData[4], mReady);
      check(regRdData[0] == expRd[0], "R7 data in", regRdData[0], expRd[0]);
      check(regRdData == expRd, "R11 read value", regRdData, expRd);
      check({eeCs, eeSck, eeDo} == (mOwned ? {mCs, mSck, mDo} : 3'b000), "R5/R6 pins",
            {eeCs, eeSck, eeDo}, mOwned ? {mCs, mSck, mDo} : 3'b000);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] d);
    @(posedge clk); #1;
    regWrEn = 1'b1; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0; regWrData = 8'h00;
  endtask

  task automatic finishRun;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    // R1 reset state
    check(regRdData == 8'h00, "R1 reset read", regRdData, 0);
    check({portReq, portOwned, eeCs, eeSck, eeDo} == 5'b0, "R1 reset outputs",
          {portReq, portOwned, eeCs, eeSck, eeDo}, 0);

    // R5: pin bits stored but not driven before grant
    wr(8'h0E);
    step(1);
    check(regRdData[3:1] == 3'b111, "R5 stored bits", regRdData[3:1], 7);
    check({eeCs, eeSck, eeDo} == 3'b000, "R5 pins idle", {eeCs, eeSck, eeDo}, 0);

    // R2/R3: request while busy
    portBusy = 1'b1;
    wr(8'h28);
    check(portReq && regRdData[6], "R2 pending", regRdData, 8'h68);
    step(6);
    check(!portOwned, "R3 no grant while busy", portOwned, 0);
    portBusy = 1'b0;
    step(1);
    // R4: grant and ready together
    check(portOwned && regRdData[4] && regRdData[7], "R4 grant with ready", regRdData, 8'hB8);
    check(eeCs, "R6 cs driven", eeCs, 1);

    // R7: data in
    eeDataIn = 1'b1; #0.5;
    check(regRdData[0], "R7 data in high", regRdData[0], 1);
    step(2);
    eeDataIn = 1'b0;
    step(1);

    // R12: busy after grant ignored
    portBusy = 1'b1;
    step(3);
    check(portOwned && regRdData[4], "R12 busy ignored", regRdData, 8'hB8);

    // R8: pacing delay
    wr(8'h2C);
    check(!regRdData[4], "R8 ready cleared", regRdData[4], 0);
    step(Dly - 1);
    check(!regRdData[4], "R8 ready not early", regRdData[4], 0);
    step(1);
    check(regRdData[4], "R8 ready on time", regRdData[4], 1);

    // R9: restart mid countdown
    wr(8'h2A);
    step(100);
    wr(8'h2E);
    step(Dly - 1);
    check(!regRdData[4], "R9 restart holds ready low", regRdData[4], 0);
    step(1);
    check(regRdData[4], "R9 ready after restart", regRdData[4], 1);

    // R11: read-only bits ignored
    wr(8'hFF ^ 8'h0E);  // sets 7,6,5,4,0 ; clears cs/sck/do
    step(1);
    check(regRdData[6] == 1'b0 && regRdData[3:1] == 3'b000, "R11 ro bits ignored",
          regRdData, 8'hA0);
    step(Dly);

    // R10: release
    portBusy = 1'b0;
    wr(8'h0E);
    check(!portOwned && !portReq && !regRdData[4] && {eeCs, eeSck, eeDo} == 3'b000,
          "R10 release", {portOwned, portReq, eeCs, eeSck, eeDo}, 0);

    // re-grant with a write landing in the grant cycle
    wr(8'h20);
    wr(8'h24);
    step(2);
    check(portOwned && eeSck, "R3 regrant", {portOwned, eeSck}, 3);
    step(Dly + 5);
    wr(8'h00);
    step(4);
    finishRun();
  end

endmodule